// File: doc/BRIEF.md
# IDE Host Interrupt and Timing Register Slice

This block is a small memory-mapped register slice for an IDE host controller. It occupies a 4 KiB window on a 32-bit register bus. Software sees two registers in it. The first is a drive-timing word that simply holds whatever was last written. The second is an interrupt status word that merges two sources: a sticky flag, set when the DMA interrupt line rises, and a live image of the disk interrupt line. Both interrupt lines are also passed unchanged to two outputs for the system interrupt controller.

The bus carries words in the opposite byte order from the registers, so every word is byte-reversed on its way in and on its way out. Register index 0 is a data port. An access there raises a one-cycle strobe towards an external task-file engine and passes the byte-reversed write data to it. Read data from that engine is returned through the same byte reversal.

The request side has no back-pressure. The block takes one request in every cycle its valid is high. Each read returns exactly one response, one cycle later. A read of index 0 expects `dp_rdata` to be valid in the same cycle as `dp_rd`.

Top module: `ide_host_regs`

## Requirements
- R1: A synchronous active-high reset clears the timing register and the DMA flag, and leaves `resp_valid` low.
- R2: The register index is taken from `req_addr[11:4]`, so registers sit 16 bytes apart. Bits [3:0] are ignored.
- R3: A write to index 0x20 (byte offset 0x200) stores the word. A later read of that index returns the same bus value. Writes to other indices leave it unchanged.
- R4: A read of index 0x30 (offset 0x300) returns a bus word that is zero except for bit 7, which holds the DMA flag (register bit 31), and bit 6, which holds the disk line (register bit 30).
- R5: A rising edge of `dma_irq` sets the DMA flag. A line that stays high sets it only once, so after it is cleared the flag stays clear while the line remains high.
- R6: A write to index 0x30 whose bus bit 7 is 1 clears only the DMA flag. A write with bus bit 7 = 0 has no effect. When a set and a clear land in the same cycle, the set wins.
- R7: Status bus bit 6 equals the level of `disk_irq` at the read's clock edge, and no write changes it.
- R8: A read of any index other than 0, 0x20 or 0x30 returns 0xFFFFFFFF. Writes to such indices change no register.
- R9: `dma_irq_out` and `disk_irq_out` follow `dma_irq` and `disk_irq` combinationally.
- R10: A request to index 0 drives `dp_wr` (write) or `dp_rd` (read) high in that cycle only. On a write, `dp_wdata` is the byte-reversed `req_wdata`. On a read, the response is the byte-reversed `dp_rdata`.
- R11: `resp_valid` is high exactly in the cycle after an accepted read and carries that read's data. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data, bus byte order |
| resp_valid | output | 1 | Read data valid |
| resp_rdata | output | 32 | Read data, bus byte order |
| dp_rd | output | 1 | Data-port read strobe |
| dp_wr | output | 1 | Data-port write strobe |
| dp_wdata | output | 32 | Data-port write data, register order |
| dp_rdata | input | 32 | Data-port read data, register order |
| dma_irq | input | 1 | DMA interrupt line |
| disk_irq | input | 1 | Disk interrupt line |
| dma_irq_out | output | 1 | DMA interrupt to the system |
| disk_irq_out | output | 1 | Disk interrupt to the system |

## Verification
The bench holds `dma_irq` high across a clearing write. A design that latches on the level instead of the edge would set the flag again at once. It also lines up a rising edge with a clear in the same cycle, which a clear-priority design would lose. Writes of all-ones to the status word catch a disk bit that can be written. Writes to unmapped and offset-aliased addresses catch a decoder that uses the wrong address bits or lets stray writes reach the timing word. Asymmetric patterns through the data port expose a missing or doubled byte reversal.

// File: rtl/ide_regs_pkg.sv
package ide_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int IDX_LSB  = 4;
  localparam int IDX_W    = ADDR_W - IDX_LSB;
  localparam int NBYTES   = DATA_W / 8;

  localparam logic [IDX_W-1:0] IDX_DATA   = 8'h00;
  localparam logic [IDX_W-1:0] IDX_TIMING = 8'h20;
  localparam logic [IDX_W-1:0] IDX_STATUS = 8'h30;

  // Bit positions inside the status register (register byte order)
  localparam int ST_DMA_BIT  = DATA_W - 1;
  localparam int ST_DISK_BIT = DATA_W - 2;

  function automatic logic [DATA_W-1:0] byte_rev(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < NBYTES; b++) begin
      r[b*8 +: 8] = d[(NBYTES-1-b)*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_regs_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              sel_data,
  output logic              sel_timing,
  output logic              sel_status,
  output logic              rd_any,
  output logic              wr_any
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx        = req_addr[IDX_LSB +: IDX_W];
    sel_data   = (idx == IDX_DATA);
    sel_timing = (idx == IDX_TIMING);
    sel_status = (idx == IDX_STATUS);
    rd_any     = req_valid && !req_write;
    wr_any     = req_valid &&  req_write;
  end
endmodule

// File: rtl/ide_irq_status.sv
module ide_irq_status (
  input  logic clk,
  input  logic rst,
  input  logic dma_line,
  input  logic clear_req,
  output logic dma_flag
);
  logic dma_prev;
  logic dma_rise;

  assign dma_rise = dma_line && !dma_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_prev <= 1'b0;
      dma_flag <= 1'b0;
    end else begin
      dma_prev <= dma_line;
      if (dma_rise)
        dma_flag <= 1'b1;          // set has priority over clear
      else if (clear_req)
        dma_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ide_host_regs.sv
module ide_host_regs
  import ide_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [11:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              dp_rd,
  output logic              dp_wr,
  output logic [31:0]       dp_wdata,
  input  logic [31:0]       dp_rdata,
  input  logic              dma_irq,
  input  logic              disk_irq,
  output logic              dma_irq_out,
  output logic              disk_irq_out
);
  logic              sel_data, sel_timing, sel_status;
  logic              rd_any, wr_any;
  logic [DATA_W-1:0] wdata_reg;
  logic [DATA_W-1:0] timing_q;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rd_mux;
  logic              dma_flag;
  logic              clear_req;

  ide_addr_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .sel_data  (sel_data),
    .sel_timing(sel_timing),
    .sel_status(sel_status),
    .rd_any    (rd_any),
    .wr_any    (wr_any)
  );

  assign wdata_reg = byte_rev(req_wdata);
  assign clear_req = wr_any && sel_status && wdata_reg[ST_DMA_BIT];

  ide_irq_status u_irq (
    .clk      (clk),
    .rst      (rst),
    .dma_line (dma_irq),
    .clear_req(clear_req),
    .dma_flag (dma_flag)
  );

  assign dma_irq_out  = dma_irq;
  assign disk_irq_out = disk_irq;

  assign dp_wr    = wr_any && sel_data;
  assign dp_rd    = rd_any && sel_data;
  assign dp_wdata = wdata_reg;

  always_comb begin
    status_word              = '0;
    status_word[ST_DMA_BIT]  = dma_flag;
    status_word[ST_DISK_BIT] = disk_irq;
  end

  always_comb begin
    if (sel_data)        rd_mux = dp_rdata;
    else if (sel_timing) rd_mux = timing_q;
    else if (sel_status) rd_mux = status_word;
    else                 rd_mux = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timing_q   <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      if (wr_any && sel_timing)
        timing_q <= wdata_reg;
      resp_valid <= rd_any;
      if (rd_any)
        resp_rdata <= byte_rev(rd_mux);
    end
  end
endmodule

// File: rtl/ide_host_regs_chk.sv
module ide_host_regs_chk
  import ide_regs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [11:0]       req_addr,
  input logic [31:0]       req_wdata,
  input logic              resp_valid,
  input logic [31:0]       resp_rdata,
  input logic              dma_irq,
  input logic              disk_irq,
  input logic              dma_flag,
  input logic [DATA_W-1:0] timing_q
);
  logic [IDX_W-1:0] c_idx;
  logic             c_rd, c_wr, c_unmapped;

  assign c_idx      = req_addr[IDX_LSB +: IDX_W];
  assign c_rd       = req_valid && !req_write;
  assign c_wr       = req_valid &&  req_write;
  assign c_unmapped = (c_idx != IDX_DATA) && (c_idx != IDX_TIMING) && (c_idx != IDX_STATUS);

  a_r11_read_responds: assert property (@(posedge clk) disable iff (rst)
    c_rd |=> resp_valid);
  a_r11_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !c_rd |=> !resp_valid);
  a_r8_unmapped_ones: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_unmapped) |=> (resp_rdata == 32'hFFFF_FFFF));
  a_r7_disk_live: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_idx == IDX_STATUS) |=> (resp_rdata[6] == $past(disk_irq)));
  a_r4_status_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_idx == IDX_STATUS) |=> (resp_rdata[31:8] == '0 && resp_rdata[5:0] == '0));
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (dma_flag && !(c_wr && c_idx == IDX_STATUS && req_wdata[7])) |=> dma_flag);
  a_r5_rise_sets: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_irq) |=> dma_flag);
  a_r3_timing_hold: assert property (@(posedge clk) disable iff (rst)
    !(c_wr && c_idx == IDX_TIMING) |=> $stable(timing_q));
endmodule

bind ide_host_regs ide_host_regs_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .resp_valid(resp_valid),
  .resp_rdata(resp_rdata),
  .dma_irq   (dma_irq),
  .disk_irq  (disk_irq),
  .dma_flag  (dma_flag),
  .timing_q  (timing_q)
);

// File: tb/ide_host_regs_bench.sv
module ide_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        dp_rd, dp_wr;
  logic [31:0] dp_wdata, dp_rdata;
  logic        dma_irq, disk_irq, dma_irq_out, disk_irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  ide_host_regs u_ide_host_regs (.*);

  // vector: {is_write, addr, wdata, expected read data}
  localparam int NV = 12;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h200, 32'h1234_5678, 32'h0},
    {1'b0, 12'h200, 32'h0,         32'h1234_5678},
    {1'b0, 12'h20C, 32'h0,         32'h1234_5678},
    {1'b1, 12'h100, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 12'h200, 32'h0,         32'h1234_5678},
    {1'b0, 12'h100, 32'h0,         32'hFFFF_FFFF},
    {1'b0, 12'hFF0, 32'h0,         32'hFFFF_FFFF},
    {1'b0, 12'h300, 32'h0,         32'h0},
    {1'b1, 12'h300, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h300, 32'h0,         32'h0},
    {1'b1, 12'h20F, 32'hA5A5_0001, 32'h0},
    {1'b0, 12'h204, 32'h0,         32'hA5A5_0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    access(1'b0, a, 32'h0);
    check({req, " rdata"}, resp_rdata, exp);
    check({req, " resp_valid"}, {31'b0, resp_valid}, 32'h1);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    dp_rdata = 0; dma_irq = 0; disk_irq = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 resp_valid after reset", {31'b0, resp_valid}, 32'h0);
    rd_check("R1 timing after reset", 12'h200, 32'h0);
    rd_check("R1 status after reset", 12'h300, 32'h0);

    // table walk: R2 R3 R4 R7 R8
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][76], VEC[i][75:64], VEC[i][63:32]);
      if (!VEC[i][76]) check($sformatf("R2/R3/R8 vec %0d", i), resp_rdata, VEC[i][31:0]);
      else check($sformatf("R11 no resp on write vec %0d", i), {31'b0, resp_valid}, 32'h0);
    end

    // R9 passthrough and R7 live disk bit
    @(negedge clk); disk_irq = 1'b1; #1;
    check("R9 disk_irq_out", {31'b0, disk_irq_out}, 32'h1);
    rd_check("R7 disk bit set", 12'h300, 32'h0000_0040);
    access(1'b1, 12'h300, 32'h0000_0000);
    rd_check("R7 disk unaffected by write", 12'h300, 32'h0000_0040);

    // R5 edge latch, held line latches once
    @(negedge clk); dma_irq = 1'b1; #1;
    check("R9 dma_irq_out", {31'b0, dma_irq_out}, 32'h1);
    repeat (3) @(negedge clk);
    rd_check("R4 both bits", 12'h300, 32'h0000_00C0);
    access(1'b1, 12'h300, 32'h0000_0080);
    rd_check("R5 held line no re-latch", 12'h300, 32'h0000_0040);
    @(negedge clk); dma_irq = 1'b0; disk_irq = 1'b0;
    rd_check("R7 disk bit follows low", 12'h300, 32'h0);

    // R6 clear semantics
    @(negedge clk); dma_irq = 1'b1;
    @(negedge clk); dma_irq = 1'b0;
    rd_check("R5 pulse latched", 12'h300, 32'h0000_0080);
    access(1'b1, 12'h300, 32'h0000_0000);
    rd_check("R6 zero write keeps flag", 12'h300, 32'h0000_0080);
    access(1'b1, 12'h300, 32'hFFFF_FF7F);
    rd_check("R6 other bits keep flag", 12'h300, 32'h0000_0080);
    access(1'b1, 12'h300, 32'h0000_0080);
    rd_check("R6 clear by bit", 12'h300, 32'h0);
    // set wins over simultaneous clear
    @(negedge clk);
    dma_irq = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h300; req_wdata = 32'h0000_0080;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; dma_irq = 1'b0;
    rd_check("R6 set wins", 12'h300, 32'h0000_0080);
    access(1'b1, 12'h300, 32'h0000_0080);

    // R10 data port write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h008; req_wdata = 32'h1122_3344;
    #1;
    check("R10 dp_wr strobe", {30'b0, dp_wr, dp_rd}, 32'h2);
    check("R10 dp_wdata swapped", dp_wdata, 32'h4433_2211);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; #1;
    check("R10 dp_wr one cycle", {30'b0, dp_wr, dp_rd}, 32'h0);
    // R10 data port read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h000; dp_rdata = 32'hAABB_CCDD;
    #1;
    check("R10 dp_rd strobe", {30'b0, dp_wr, dp_rd}, 32'h1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R10 read swapped", resp_rdata, 32'hDDCC_BBAA);
    @(negedge clk);
    check("R11 resp_valid drops", {31'b0, resp_valid}, 32'h0);

    // R1 reset mid-run
    access(1'b1, 12'h200, 32'hCAFE_F00D);
    @(negedge clk); dma_irq = 1'b1;
    @(negedge clk); dma_irq = 1'b0;
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_check("R1 timing cleared", 12'h200, 32'h0);
    rd_check("R1 dma flag cleared", 12'h300, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule